// File: doc/BRIEF.md
# Video Memory Word Write Port with Auto-Increment

This block sits between a byte-wide processor register bus and a video memory organised as 16-bit words. Software first loads a word pointer through two byte registers, one for the low eight bits and one for the upper bits. It then streams pixel or tile data through two data registers, one for each half of a word. Each data write becomes a single-cycle, byte-enabled write to the memory at the current pointer.

After each word, the pointer steps by one without any further software action. A step-select bit in a mode register sets which half-word write moves the pointer. With the bit set, the pointer steps after the upper-byte write, which suits software that writes the low half first. With the bit clear, the pointer steps after the lower-byte write, which suits software that writes the high half first. Either order therefore fills consecutive whole words. The current pointer is always visible as an output, so a bulk copy engine or a debugger can see how far a transfer has gone.

Top module: `vram_port`

## Requirements
- R1: While reset is asserted and right after it is released, `cur_addr` is 0, `mem_we` is 0, and the step-select bit is clear.
- R2: A write with `cpu_sel`=1 sets pointer bits 7:0 from `cpu_wdata`. A write with `cpu_sel`=2 sets pointer bits 14:8 from `cpu_wdata[6:0]`, and `cpu_wdata[7]` is ignored. Either write shows on `cur_addr` one cycle later, with no increment and no memory write.
- R3: A write with `cpu_sel`=3 causes, one cycle later, a single-cycle `mem_we` pulse. The pulse carries `mem_be`=2'b01, `mem_wdata`={8'h00, byte}, and `mem_addr` equal to the pointer before the write.
- R4: A write with `cpu_sel`=4 causes, one cycle later, a single-cycle `mem_we` pulse. The pulse carries `mem_be`=2'b10, `mem_wdata`={byte, 8'h00}, and `mem_addr` equal to the pointer before the write.
- R5: With the step-select bit clear, the pointer increases by 1 on each `cpu_sel`=3 write and holds on each `cpu_sel`=4 write.
- R6: With the step-select bit set, the pointer increases by 1 on each `cpu_sel`=4 write and holds on each `cpu_sel`=3 write.
- R7: The pointer is 15 bits wide, and an increment from 0x7FFF gives 0x0000.
- R8: A write with `cpu_sel`=0 loads the step-select bit from `cpu_wdata[7]`. Bits 6:0 have no effect. The write changes neither the pointer nor the memory port.
- R9: Cycles with `cpu_we` low, and writes with `cpu_sel` 5 to 7, leave the pointer unchanged and produce no memory write.
- R10: With the step-select bit set and 0x400 low-then-high word writes starting at 0x2000, every word lands intact and the pointer ends at 0x2400. With the bit clear, high-then-low writes also land whole words at consecutive addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_we | input | 1 | Processor register write strobe |
| cpu_sel | input | 3 | Register select: 0 mode, 1 pointer low, 2 pointer high, 3 data low, 4 data high |
| cpu_wdata | input | 8 | Processor write byte |
| mem_we | output | 1 | Video memory write strobe |
| mem_addr | output | 15 | Video memory word address |
| mem_wdata | output | 16 | Video memory write word; the disabled lane is zero |
| mem_be | output | 2 | Byte enables: bit 0 low byte, bit 1 high byte |
| cur_addr | output | 15 | Current word pointer |

## Verification
The assertions check the single-cycle rules on every cycle: the lane, data and pre-write address of each memory pulse, the step or hold of the pointer for each data write under either step-select setting, pointer loads without increment, and quiet idle cycles. Only the bench scenarios can show the effects that build up over many writes. These are the 0x400-word fill that ends at 0x2400 with every word intact, the reversed write order that still gives whole words, the wrap at the top of the pointer range, and the proof that ignored mode bits and unused selects leave no trace.

// File: rtl/vram_port_pkg.sv
package vram_port_pkg;

  localparam int BYTE_W  = 8;
  localparam int LANES   = 2;
  localparam int SEL_W   = 3;
  localparam int STEP_BIT = 7;

  typedef enum logic [SEL_W-1:0] {
    SEL_MODE    = 3'd0,
    SEL_PTR_LO  = 3'd1,
    SEL_PTR_HI  = 3'd2,
    SEL_DATA_LO = 3'd3,
    SEL_DATA_HI = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic mode_wr;
    logic ptr_lo_wr;
    logic ptr_hi_wr;
    logic [LANES-1:0] lane_wr;
  } strobe_t;

endpackage

// File: rtl/vram_reg_decode.sv
module vram_reg_decode
  import vram_port_pkg::*;
(
  input  logic             cpu_we,
  input  logic [SEL_W-1:0] cpu_sel,
  output strobe_t          strobes
);

  always_comb begin
    strobes = '0;
    if (cpu_we) begin
      unique case (cpu_sel)
        SEL_MODE:    strobes.mode_wr    = 1'b1;
        SEL_PTR_LO:  strobes.ptr_lo_wr  = 1'b1;
        SEL_PTR_HI:  strobes.ptr_hi_wr  = 1'b1;
        SEL_DATA_LO: strobes.lane_wr[0] = 1'b1;
        SEL_DATA_HI: strobes.lane_wr[1] = 1'b1;
        default:     strobes = '0;
      endcase
    end
  end

endmodule

// File: rtl/vram_step_mode.sv
module vram_step_mode
  import vram_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_wr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [LANES-1:0]  lane_wr,
  output logic              step_on_high,
  output logic              step
);

  logic mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (mode_wr) mode_d = wdata[STEP_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else if (mode_wr) mode_q <= mode_d;
  end

  assign step_on_high = mode_q;
  assign step = mode_q ? lane_wr[1] : lane_wr[0];

endmodule

// File: rtl/vram_addr_ctr.sv
module vram_addr_ctr
  import vram_port_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_lo,
  input  logic              load_hi,
  input  logic              step,
  input  logic [BYTE_W-1:0] wdata,
  output logic [ADDR_W-1:0] addr
);

  localparam int HI_W = ADDR_W - BYTE_W;

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              addr_en;

  assign addr_en = load_lo | load_hi | step;

  always_comb begin
    addr_d = addr_q;
    if (load_lo)      addr_d[BYTE_W-1:0]      = wdata;
    else if (load_hi) addr_d[ADDR_W-1:BYTE_W] = wdata[HI_W-1:0];
    else if (step)    addr_d = addr_q + ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr = addr_q;

endmodule

// File: rtl/vram_wr_stage.sv
module vram_wr_stage
  import vram_port_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LANES-1:0]         lane_wr,
  input  logic [BYTE_W-1:0]        wdata,
  input  logic [ADDR_W-1:0]        addr,
  output logic                     mem_we,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [LANES*BYTE_W-1:0]  mem_wdata,
  output logic [LANES-1:0]         mem_be
);

  logic                    we_q, we_d;
  logic [ADDR_W-1:0]       addr_q;
  logic [LANES*BYTE_W-1:0] data_q, data_d;
  logic [LANES-1:0]        be_q, be_d;
  logic                    cap_en;

  assign we_d   = |lane_wr;
  assign cap_en = we_d | we_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      be_d[g] = lane_wr[g];
      data_d[g*BYTE_W +: BYTE_W] = lane_wr[g] ? wdata : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b0;
    else        we_q <= we_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      be_q   <= '0;
    end else if (cap_en) begin
      addr_q <= addr;
      data_q <= data_d;
      be_q   <= be_d;
    end
  end

  assign mem_we    = we_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
  assign mem_be    = be_q;

endmodule

// File: rtl/vram_port.sv
module vram_port
  import vram_port_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_we,
  input  logic [SEL_W-1:0]        cpu_sel,
  input  logic [BYTE_W-1:0]       cpu_wdata,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [LANES*BYTE_W-1:0] mem_wdata,
  output logic [LANES-1:0]        mem_be,
  output logic [ADDR_W-1:0]       cur_addr
);

  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  strobe_t strobes;
  logic    step_on_high;
  logic    step;

  vram_reg_decode u_dec (
    .cpu_we  (cpu_we),
    .cpu_sel (cpu_sel),
    .strobes (strobes)
  );

  vram_step_mode u_mode (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .mode_wr      (strobes.mode_wr),
    .wdata        (cpu_wdata),
    .lane_wr      (strobes.lane_wr),
    .step_on_high (step_on_high),
    .step         (step)
  );

  vram_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_lo (strobes.ptr_lo_wr),
    .load_hi (strobes.ptr_hi_wr),
    .step    (step),
    .wdata   (cpu_wdata),
    .addr    (cur_addr)
  );

  vram_wr_stage #(.ADDR_W(ADDR_W)) u_wr (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .lane_wr   (strobes.lane_wr),
    .wdata     (cpu_wdata),
    .addr      (cur_addr),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_be    (mem_be)
  );

endmodule

// File: rtl/vram_port_chk.sv
module vram_port_chk
  import vram_port_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input logic                    clk,
  input logic                    rst_sync_n,
  input logic                    cpu_we,
  input logic [SEL_W-1:0]        cpu_sel,
  input logic [BYTE_W-1:0]       cpu_wdata,
  input logic                    step_on_high,
  input logic                    mem_we,
  input logic [ADDR_W-1:0]       mem_addr,
  input logic [LANES*BYTE_W-1:0] mem_wdata,
  input logic [LANES-1:0]        mem_be,
  input logic [ADDR_W-1:0]       cur_addr
);

  localparam int HI_W = ADDR_W - BYTE_W;

  logic wr_lo, wr_hi, wr_plo, wr_phi, quiet;
  assign wr_lo  = cpu_we && cpu_sel == SEL_DATA_LO;
  assign wr_hi  = cpu_we && cpu_sel == SEL_DATA_HI;
  assign wr_plo = cpu_we && cpu_sel == SEL_PTR_LO;
  assign wr_phi = cpu_we && cpu_sel == SEL_PTR_HI;
  assign quiet  = !cpu_we || cpu_sel == SEL_MODE || cpu_sel > SEL_DATA_HI;

  // R3
  a_r3_low_lane: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_lo |=> mem_we && mem_be == 2'b01 && mem_addr == $past(cur_addr)
              && mem_wdata == {8'h00, $past(cpu_wdata)});

  // R4
  a_r4_high_lane: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_hi |=> mem_we && mem_be == 2'b10 && mem_addr == $past(cur_addr)
              && mem_wdata == {$past(cpu_wdata), 8'h00});

  // R5
  a_r5_step_low: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!step_on_high && wr_lo) |=> cur_addr == $past(cur_addr) + ADDR_W'(1));
  a_r5_hold_high: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!step_on_high && wr_hi) |=> $stable(cur_addr));

  // R6
  a_r6_step_high: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_on_high && wr_hi) |=> cur_addr == $past(cur_addr) + ADDR_W'(1));
  a_r6_hold_low: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step_on_high && wr_lo) |=> $stable(cur_addr));

  // R2
  a_r2_ptr_lo: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_plo |=> !mem_we && cur_addr[BYTE_W-1:0] == $past(cpu_wdata)
               && cur_addr[ADDR_W-1:BYTE_W] == $past(cur_addr[ADDR_W-1:BYTE_W]));
  a_r2_ptr_hi: assert property (@(posedge clk) disable iff (!rst_sync_n)
    wr_phi |=> !mem_we && cur_addr[ADDR_W-1:BYTE_W] == $past(cpu_wdata[HI_W-1:0])
               && cur_addr[BYTE_W-1:0] == $past(cur_addr[BYTE_W-1:0]));

  // R8 / R9
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_sync_n)
    quiet |=> !mem_we && $stable(cur_addr));

  // R3 / R4 lane exclusivity
  a_r3_one_lane: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_we |-> $countones(mem_be) == 1);

endmodule

bind vram_port vram_port_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .cpu_we       (cpu_we),
  .cpu_sel      (cpu_sel),
  .cpu_wdata    (cpu_wdata),
  .step_on_high (step_on_high),
  .mem_we       (mem_we),
  .mem_addr     (mem_addr),
  .mem_wdata    (mem_wdata),
  .mem_be       (mem_be),
  .cur_addr     (cur_addr)
);

// File: tb/vram_port_bench.sv
`timescale 1ns/1ps
module vram_port_bench;

  localparam int AW = 15;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_we;
  logic [2:0]    cpu_sel;
  logic [7:0]    cpu_wdata;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [15:0]   mem_wdata;
  logic [1:0]    mem_be;
  logic [AW-1:0] cur_addr;

  always #2.5 clk = ~clk;

  vram_port u_vram_port (
    .clk (clk), .rst_n (rst_n), .cpu_we (cpu_we), .cpu_sel (cpu_sel),
    .cpu_wdata (cpu_wdata), .mem_we (mem_we), .mem_addr (mem_addr),
    .mem_wdata (mem_wdata), .mem_be (mem_be), .cur_addr (cur_addr)
  );

  int checks = 0;
  int errors = 0;
  logic          m_mode;
  logic [AW-1:0] m_addr;
  logic [15:0]   img [int];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(logic we, logic [2:0] sel);
    if (!we || sel > 3'd4) return "R9";
    case (sel)
      3'd0: return "R8";
      3'd1, 3'd2: return "R2";
      3'd3: return m_mode ? "R6" : "R5";
      default: return m_mode ? "R6" : "R5";
    endcase
  endfunction

  // One register access; model predicted, outputs checked one cycle later.
  task automatic op(logic we, logic [2:0] sel, logic [7:0] d);
    logic          e_we;
    logic [1:0]    e_be;
    logic [15:0]   e_dat;
    logic [AW-1:0] e_maddr;
    string         t;
    t = tag_of(we, sel);
    e_we = 1'b0; e_be = 2'b00; e_dat = 16'h0; e_maddr = m_addr;
    cpu_we = we; cpu_sel = sel; cpu_wdata = d;
    @(posedge clk);
    @(negedge clk);
    cpu_we = 1'b0;
    if (we) begin
      case (sel)
        3'd0: m_mode = d[7];
        3'd1: m_addr[7:0] = d;
        3'd2: m_addr[14:8] = d[6:0];
        3'd3: begin
          e_we = 1'b1; e_be = 2'b01; e_dat = {8'h00, d};
          if (!m_mode) m_addr = m_addr + 1'b1;
        end
        3'd4: begin
          e_we = 1'b1; e_be = 2'b10; e_dat = {d, 8'h00};
          if (m_mode) m_addr = m_addr + 1'b1;
        end
        default: ;
      endcase
    end
    chk(t, mem_we, e_we);
    chk(t, cur_addr, m_addr);
    if (e_we) begin
      chk(e_be[0] ? "R3" : "R4", mem_be, e_be);
      chk(e_be[0] ? "R3" : "R4", mem_addr, e_maddr);
      chk(e_be[0] ? "R3" : "R4", mem_wdata, e_dat);
    end
    if (mem_we) begin
      logic [15:0] w;
      w = img.exists(int'(mem_addr)) ? img[int'(mem_addr)] : 16'h0;
      if (mem_be[0]) w[7:0]  = mem_wdata[7:0];
      if (mem_be[1]) w[15:8] = mem_wdata[15:8];
      img[int'(mem_addr)] = w;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    cpu_we = 1'b0; cpu_sel = 3'd0; cpu_wdata = 8'h00;
    m_mode = 1'b0; m_addr = '0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", cur_addr, 0);
    chk("R1", mem_we, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", cur_addr, 0);
    chk("R1", mem_we, 0);
    // R1: step-select clear, so low write steps
    op(1'b1, 3'd3, 8'h11);
    chk("R1", cur_addr, 1);

    // R2: pointer load, bit 7 of high byte ignored
    op(1'b1, 3'd2, 8'hFF);
    op(1'b1, 3'd1, 8'h34);
    chk("R2", cur_addr, 15'h7F34);

    // R7: wrap at top
    op(1'b1, 3'd1, 8'hFF);
    op(1'b1, 3'd3, 8'hAA);
    chk("R7", cur_addr, 15'h0000);
    op(1'b1, 3'd0, 8'h80);
    op(1'b1, 3'd2, 8'h7F);
    op(1'b1, 3'd1, 8'hFF);
    op(1'b1, 3'd4, 8'h55);
    chk("R7", cur_addr, 15'h0000);

    // R8: mode write with low bits only clears step-select; no pointer change
    op(1'b1, 3'd1, 8'h40);
    op(1'b1, 3'd0, 8'h7F);
    chk("R8", cur_addr, 15'h0040);
    op(1'b1, 3'd4, 8'h01);
    chk("R8", cur_addr, 15'h0040);

    // R9: unused selects and idle cycles
    op(1'b1, 3'd5, 8'hFF);
    op(1'b1, 3'd7, 8'hFF);
    op(1'b0, 3'd3, 8'hFF);
    chk("R9", cur_addr, 15'h0040);

    // R10: 0x400 words low-then-high from 0x2000, step after high
    op(1'b1, 3'd0, 8'h80);
    op(1'b1, 3'd2, 8'h20);
    op(1'b1, 3'd1, 8'h00);
    for (int i = 0; i < 'h400; i++) begin
      op(1'b1, 3'd3, i[7:0]);
      op(1'b1, 3'd4, i[15:8]);
    end
    chk("R10", cur_addr, 15'h2400);
    for (int i = 0; i < 'h400; i++)
      chk("R10", img.exists('h2000 + i) ? img['h2000 + i] : 16'hDEAD, i);

    // R10: reversed order with step after low, from 0x0100
    op(1'b1, 3'd0, 8'h00);
    op(1'b1, 3'd2, 8'h01);
    op(1'b1, 3'd1, 8'h00);
    for (int i = 0; i < 64; i++) begin
      op(1'b1, 3'd4, 8'hC0 ^ i[7:0]);
      op(1'b1, 3'd3, i[7:0]);
    end
    chk("R10", cur_addr, 15'h0140);
    for (int i = 0; i < 64; i++)
      chk("R10", img.exists('h100 + i) ? img['h100 + i] : 16'hDEAD,
          {8'hC0 ^ i[7:0], i[7:0]});

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      logic [2:0] s;
      int r;
      r = $urandom_range(0, 15);
      s = (r < 6) ? 3'd3 : (r < 12) ? 3'd4 : 3'($urandom_range(0, 7));
      op($urandom_range(0, 9) != 0, s, 8'($urandom));
    end

    finish_run();
  end

endmodule